// File: doc/BRIEF.md
# Floating-Point Classify and Register Move Unit

This unit sits beside a floating-point datapath and handles two small jobs that need no arithmetic. It sorts one single- or double-precision operand into one of ten categories and reports the category as a one-hot mask. It also copies raw bit patterns between the floating-point and integer register domains. The unit is purely combinational. The caller presents the operands, a 7-bit function code and a 3-bit sub-operation field, and reads the 64-bit result in the same cycle.

Two function codes read the floating-point operand, one for each precision. On them, the sub-operation selects either a raw move to the integer side or classification. Two more function codes copy the integer operand into the floating-point domain. Any other combination of function code and sub-operation yields an all-zero result.

Top module: `fp_class_move`

## Requirements
- R1: Function code 0x70 works on the low 32 bits of `fp_opnd` as single precision, and 0x71 works on all 64 bits as double precision. On either code, `sub_op` 0 selects a move to the integer side and `sub_op` 1 selects classification.
- R2: The classification mask uses these bit positions: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. The sign bit does not affect the two NaN classes.
- R3: On classification, exactly one of result bits 9..0 is set, and result bits 63..10 are zero.
- R4: An operand with a zero exponent is a zero when its fraction is zero and a subnormal when its fraction is non-zero. An operand whose exponent is neither all zeros nor all ones is a normal. An operand with an all-ones exponent and a zero fraction is an infinity.
- R5: An operand with an all-ones exponent and a non-zero fraction is a quiet NaN when its most significant fraction bit is 1. Otherwise it is a signaling NaN.
- R6: The single-precision move to the integer side (0x70, `sub_op` 0) returns `fp_opnd[31:0]` in the low half and fills bits 63..32 with copies of `fp_opnd[31]`.
- R7: The double-precision move to the integer side (0x71, `sub_op` 0) returns `fp_opnd` unchanged.
- R8: Function code 0x78 returns `int_opnd[31:0]` in the low half and zeros in bits 63..32, whatever the value of `sub_op`.
- R9: Function code 0x79 returns `int_opnd` unchanged, whatever the value of `sub_op`.
- R10: Any other function code, and 0x70 or 0x71 with `sub_op` above 1, returns zero.
- R11: Single-precision classification ignores `fp_opnd[63:32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fp_opnd | input | 64 | Operand from the floating-point register domain |
| int_opnd | input | 64 | Operand from the integer register domain |
| func_code | input | 7 | Function code that selects the operation |
| sub_op | input | 3 | Sub-operation field, used with codes 0x70 and 0x71 |
| result | output | 64 | Class mask or moved bit pattern |

## Verification
Every result is combinational, so each one is due in the same cycle as its stimulus, with no register on the path. The bench applies each stimulus just after a rising clock edge. It reads `result` at the following falling edge, half a period later, when the inputs have long settled and no clock edge is near. The embedded assertions evaluate on every input change, so they check each result within that same window.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;
  localparam int XLEN  = 64;
  localparam int HALF  = XLEN / 2;
  localparam int CLS_W = 10;
  localparam int FC_W  = 7;
  localparam int SUB_W = 3;

  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;

  localparam logic [FC_W-1:0] FC_FP_SIDE_S = 7'h70;
  localparam logic [FC_W-1:0] FC_FP_SIDE_D = 7'h71;
  localparam logic [FC_W-1:0] FC_TO_FP_S   = 7'h78;
  localparam logic [FC_W-1:0] FC_TO_FP_D   = 7'h79;

  localparam logic [SUB_W-1:0] SUB_MOVE  = 3'd0;
  localparam logic [SUB_W-1:0] SUB_CLASS = 3'd1;

  localparam int CB_NEG_INF  = 0;
  localparam int CB_NEG_NORM = 1;
  localparam int CB_NEG_SUB  = 2;
  localparam int CB_NEG_ZERO = 3;
  localparam int CB_POS_ZERO = 4;
  localparam int CB_POS_SUB  = 5;
  localparam int CB_POS_NORM = 6;
  localparam int CB_POS_INF  = 7;
  localparam int CB_SNAN     = 8;
  localparam int CB_QNAN     = 9;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MV_X_S,
    OP_MV_X_D,
    OP_CLS_S,
    OP_CLS_D,
    OP_MV_F_S,
    OP_MV_F_D
  } fpcm_op_e;
endpackage

// File: rtl/fpcm_classifier.sv
module fpcm_classifier
  import fpcm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] value,
  output logic [CLS_W-1:0]      mask
);
  localparam int MSB = EXP_W + FRAC_W;

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_zero;
  logic              quiet_bit;

  assign sign      = value[MSB];
  assign expo      = value[FRAC_W +: EXP_W];
  assign frac      = value[FRAC_W-1:0];
  assign exp_ones  = &expo;
  assign exp_zero  = ~|expo;
  assign frac_zero = ~|frac;
  assign quiet_bit = frac[FRAC_W-1];

  always_comb begin
    mask = '0;
    if (exp_ones) begin
      if (frac_zero) begin
        if (sign) mask[CB_NEG_INF] = 1'b1;
        else      mask[CB_POS_INF] = 1'b1;
      end else if (quiet_bit) begin
        mask[CB_QNAN] = 1'b1;
      end else begin
        mask[CB_SNAN] = 1'b1;
      end
    end else if (exp_zero) begin
      if (frac_zero) begin
        if (sign) mask[CB_NEG_ZERO] = 1'b1;
        else      mask[CB_POS_ZERO] = 1'b1;
      end else begin
        if (sign) mask[CB_NEG_SUB] = 1'b1;
        else      mask[CB_POS_SUB] = 1'b1;
      end
    end else begin
      if (sign) mask[CB_NEG_NORM] = 1'b1;
      else      mask[CB_POS_NORM] = 1'b1;
    end
  end

  always_comb begin
    assert_one_class_R3: assert ($onehot(mask))
      else $error("class mask not one-hot: %b", mask);
    if (exp_ones && !frac_zero) begin
      assert_nan_kind_R5: assert (mask[CB_QNAN] == quiet_bit && mask[CB_SNAN] == !quiet_bit)
        else $error("NaN kind wrong: %b", mask);
    end
    if (exp_zero) begin
      assert_zero_sub_R4: assert ((mask[CB_NEG_ZERO] | mask[CB_POS_ZERO]) == frac_zero)
        else $error("zero/subnormal split wrong: %b", mask);
    end
  end
endmodule

// File: rtl/fpcm_decode.sv
module fpcm_decode
  import fpcm_pkg::*;
(
  input  logic [FC_W-1:0]  func_code,
  input  logic [SUB_W-1:0] sub_op,
  output fpcm_op_e         op
);
  always_comb begin
    op = OP_NONE;
    unique case (func_code)
      FC_FP_SIDE_S: begin
        if (sub_op == SUB_MOVE)       op = OP_MV_X_S;
        else if (sub_op == SUB_CLASS) op = OP_CLS_S;
      end
      FC_FP_SIDE_D: begin
        if (sub_op == SUB_MOVE)       op = OP_MV_X_D;
        else if (sub_op == SUB_CLASS) op = OP_CLS_D;
      end
      FC_TO_FP_S: op = OP_MV_F_S;
      FC_TO_FP_D: op = OP_MV_F_D;
      default:    op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/fpcm_move.sv
module fpcm_move
  import fpcm_pkg::*;
(
  input  fpcm_op_e         op,
  input  logic [XLEN-1:0]  fp_opnd,
  input  logic [XLEN-1:0]  int_opnd,
  output logic [XLEN-1:0]  moved
);
  always_comb begin
    unique case (op)
      OP_MV_X_S: moved = {{HALF{fp_opnd[HALF-1]}}, fp_opnd[HALF-1:0]};
      OP_MV_X_D: moved = fp_opnd;
      OP_MV_F_S: moved = {{HALF{1'b0}}, int_opnd[HALF-1:0]};
      OP_MV_F_D: moved = int_opnd;
      default:   moved = '0;
    endcase
  end
endmodule

// File: rtl/fp_class_move.sv
module fp_class_move
  import fpcm_pkg::*;
(
  input  logic [63:0] fp_opnd,
  input  logic [63:0] int_opnd,
  input  logic [6:0]  func_code,
  input  logic [2:0]  sub_op,
  output logic [63:0] result
);
  fpcm_op_e          op;
  logic [CLS_W-1:0]  mask_s;
  logic [CLS_W-1:0]  mask_d;
  logic [XLEN-1:0]   moved;

  fpcm_decode u_decode (
    .func_code (func_code),
    .sub_op    (sub_op),
    .op        (op)
  );

  fpcm_classifier #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls_s (
    .value (fp_opnd[HALF-1:0]),
    .mask  (mask_s)
  );

  fpcm_classifier #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls_d (
    .value (fp_opnd),
    .mask  (mask_d)
  );

  fpcm_move u_move (
    .op       (op),
    .fp_opnd  (fp_opnd),
    .int_opnd (int_opnd),
    .moved    (moved)
  );

  always_comb begin
    unique case (op)
      OP_CLS_S: result = {{(XLEN-CLS_W){1'b0}}, mask_s};
      OP_CLS_D: result = {{(XLEN-CLS_W){1'b0}}, mask_d};
      default:  result = moved;
    endcase
  end

  always_comb begin
    if (func_code == FC_FP_SIDE_S || func_code == FC_FP_SIDE_D) begin
      if (sub_op == SUB_CLASS) begin
        assert_class_upper_zero_R3: assert (result[XLEN-1:CLS_W] == '0 && $onehot(result[CLS_W-1:0]))
          else $error("classify result malformed: %h", result);
      end
    end
    if (func_code == FC_FP_SIDE_S && sub_op == SUB_MOVE) begin
      assert_sext_move_R6: assert (result[XLEN-1:HALF] == {HALF{fp_opnd[HALF-1]}})
        else $error("single move not sign-extended: %h", result);
    end
    if (func_code == FC_FP_SIDE_D && sub_op == SUB_MOVE) begin
      assert_dp_move_R7: assert (result == fp_opnd)
        else $error("double move altered bits: %h", result);
    end
    if (func_code == FC_TO_FP_S) begin
      assert_sp_to_fp_R8: assert (result[XLEN-1:HALF] == '0 && result[HALF-1:0] == int_opnd[HALF-1:0])
        else $error("single move to fp wrong: %h", result);
    end
    if (func_code == FC_TO_FP_D) begin
      assert_dp_to_fp_R9: assert (result == int_opnd)
        else $error("double move to fp wrong: %h", result);
    end
    if (func_code != FC_FP_SIDE_S && func_code != FC_FP_SIDE_D &&
        func_code != FC_TO_FP_S && func_code != FC_TO_FP_D) begin
      assert_other_zero_R10: assert (result == '0)
        else $error("unrecognized code gave %h", result);
    end
  end
endmodule

// File: tb/fp_class_move_tb.sv
module fp_class_move_tb_top;
  logic        clk;
  logic [63:0] fp_opnd;
  logic [63:0] int_opnd;
  logic [6:0]  func_code;
  logic [2:0]  sub_op;
  logic [63:0] result;

  int checks_run;
  int checks_failed;

  fp_class_move dut_i (
    .fp_opnd   (fp_opnd),
    .int_opnd  (int_opnd),
    .func_code (func_code),
    .sub_op    (sub_op),
    .result    (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic apply_check(input logic [6:0] fc, input logic [2:0] so,
                             input logic [63:0] fpv, input logic [63:0] iv,
                             input logic [63:0] exp_v, input string req);
    @(posedge clk);
    #1;
    func_code = fc;
    sub_op    = so;
    fp_opnd   = fpv;
    int_opnd  = iv;
    @(negedge clk);
    checks_run++;
    if (result !== exp_v) begin
      checks_failed++;
      $display("FAIL %s: code=%h sub=%0d actual=%h expected=%h", req, fc, so, result, exp_v);
    end
  endtask

  function automatic logic [63:0] bit_at(input int idx);
    return 64'd1 << idx;
  endfunction

  task automatic test_idle_state;
    apply_check(7'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R10");
  endtask

  task automatic test_classify_single;
    apply_check(7'h70, 3'd1, 64'h0000_0000_FF80_0000, 64'd0, bit_at(0), "R2");
    apply_check(7'h70, 3'd1, 64'h0000_0000_BF80_0000, 64'd0, bit_at(1), "R2");
    apply_check(7'h70, 3'd1, 64'h0000_0000_8000_0001, 64'd0, bit_at(2), "R4");
    apply_check(7'h70, 3'd1, 64'h0000_0000_8000_0000, 64'd0, bit_at(3), "R4");
    apply_check(7'h70, 3'd1, 64'h0000_0000_0000_0000, 64'd0, bit_at(4), "R4");
    apply_check(7'h70, 3'd1, 64'h0000_0000_0040_0000, 64'd0, bit_at(5), "R4");
    apply_check(7'h70, 3'd1, 64'h0000_0000_3F80_0000, 64'd0, bit_at(6), "R2");
    apply_check(7'h70, 3'd1, 64'h0000_0000_7F80_0000, 64'd0, bit_at(7), "R2");
    apply_check(7'h70, 3'd1, 64'h0000_0000_7F80_0001, 64'd0, bit_at(8), "R5");
    apply_check(7'h70, 3'd1, 64'h0000_0000_7FC0_0000, 64'd0, bit_at(9), "R5");
    apply_check(7'h70, 3'd1, 64'h0000_0000_FFA0_0000, 64'd0, bit_at(8), "R5");
    apply_check(7'h70, 3'd1, 64'h0000_0000_FFFF_FFFF, 64'd0, bit_at(9), "R3");
  endtask

  task automatic test_classify_double;
    apply_check(7'h71, 3'd1, 64'hFFF0_0000_0000_0000, 64'd0, bit_at(0), "R2");
    apply_check(7'h71, 3'd1, 64'hBFF0_0000_0000_0000, 64'd0, bit_at(1), "R2");
    apply_check(7'h71, 3'd1, 64'h8000_0000_0000_0001, 64'd0, bit_at(2), "R4");
    apply_check(7'h71, 3'd1, 64'h8000_0000_0000_0000, 64'd0, bit_at(3), "R4");
    apply_check(7'h71, 3'd1, 64'h0000_0000_0000_0000, 64'd0, bit_at(4), "R4");
    apply_check(7'h71, 3'd1, 64'h0008_0000_0000_0000, 64'd0, bit_at(5), "R4");
    apply_check(7'h71, 3'd1, 64'h3FF0_0000_0000_0000, 64'd0, bit_at(6), "R1");
    apply_check(7'h71, 3'd1, 64'h7FF0_0000_0000_0000, 64'd0, bit_at(7), "R2");
    apply_check(7'h71, 3'd1, 64'h7FF0_0000_0000_0001, 64'd0, bit_at(8), "R5");
    apply_check(7'h71, 3'd1, 64'h7FF8_0000_0000_0000, 64'd0, bit_at(9), "R5");
    apply_check(7'h71, 3'd1, 64'h0000_0000_7F80_0000, 64'd0, bit_at(5), "R1");
  endtask

  task automatic test_single_ignores_upper;
    apply_check(7'h70, 3'd1, 64'hFFFF_FFFF_3F80_0000, 64'd0, bit_at(6), "R11");
    apply_check(7'h70, 3'd1, 64'h7FF8_0000_8000_0000, 64'd0, bit_at(3), "R11");
  endtask

  task automatic test_moves_to_int;
    apply_check(7'h70, 3'd0, 64'h1234_5678_8000_0001, 64'd0, 64'hFFFF_FFFF_8000_0001, "R6");
    apply_check(7'h70, 3'd0, 64'hFFFF_FFFF_7FFF_FFFF, 64'd0, 64'h0000_0000_7FFF_FFFF, "R6");
    apply_check(7'h71, 3'd0, 64'h8123_4567_89AB_CDEF, 64'd0, 64'h8123_4567_89AB_CDEF, "R7");
  endtask

  task automatic test_moves_to_fp;
    apply_check(7'h78, 3'd0, 64'd0, 64'hAAAA_5555_DEAD_BEEF, 64'h0000_0000_DEAD_BEEF, "R8");
    apply_check(7'h78, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_8000_0000, 64'h0000_0000_8000_0000, "R8");
    apply_check(7'h79, 3'd0, 64'd0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, "R9");
    apply_check(7'h79, 3'd7, 64'h1111_1111_1111_1111, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, "R9");
  endtask

  task automatic test_unused_codes;
    apply_check(7'h53, 3'd0, 64'h3FF0_0000_0000_0000, 64'h5555_5555_5555_5555, 64'd0, "R10");
    apply_check(7'h70, 3'd2, 64'h3F80_0000_3F80_0000, 64'h1, 64'd0, "R10");
    apply_check(7'h71, 3'd7, 64'h7FF0_0000_0000_0000, 64'h1, 64'd0, "R10");
    apply_check(7'h7A, 3'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R10");
  endtask

  initial begin
    checks_run    = 0;
    checks_failed = 0;
    func_code = 7'h00;
    sub_op    = 3'd0;
    fp_opnd   = 64'd0;
    int_opnd  = 64'd0;
    test_idle_state();
    test_classify_single();
    test_classify_double();
    test_single_ignores_upper();
    test_moves_to_int();
    test_moves_to_fp();
    test_unused_codes();
    $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_failed);
    $finish;
  end

  initial begin
    #200000;
    checks_run++;
    checks_failed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_failed);
    $finish;
  end
endmodule